// File: doc/BRIEF.md
# Authentication-Gated Verification Queue

This block sits between an encrypted external memory and a processor core. Each memory line arrives with its ciphertext, a decryption pad that was prepared while the fetch was in flight, a line identifier and the MAC stored with the line. The block forms the plaintext at once by XOR. It gives the line a verification tag and sends a verification request to an external MAC engine. The line is then held in an in-order queue until the engine answers.

A 2-bit policy input chooses when plaintext may reach the core and when new bus activity may start:
- **0, issue gate:** plaintext is held until its line passes verification.
- **1, write gate:** plaintext is released at once, and memory writes wait until the queue is empty.
- **2, fetch gate:** plaintext is released at once, and new memory fetches wait until the queue is empty.
- **3, both gates:** plaintext is released at once, and both writes and fetches wait.

The policy may only be changed while the queue is empty.

A failed verification latches a tamper flag. An answer that does not belong to the oldest outstanding line latches a protocol-error flag. Either flag stops all further fetches and writes until reset.

Top module: `authGateQueue`

## Requirements
- R1: In policies 1, 2 and 3, an accepted line appears on the release port in the cycle after acceptance, with data equal to ciphertext XOR pad and with its line ID.
- R2: In policy 0, no line is released until a passing result arrives for the oldest outstanding tag. That line is released in the cycle after the result, and lines are released in arrival order.
- R3: An accepted line produces a verification request in the same cycle, carrying its tag, line ID, ciphertext and MAC. Tags start at 0 after reset and increase by one per accepted line, modulo 2^TAG_W.
- R4: In policies 1 and 3, while any line is outstanding, the write-request ready is low and no memory write is issued.
- R5: In policies 2 and 3, while any line is outstanding, the fetch-request ready is low and no memory fetch is issued.
- R6: Outside the gates of R4 and R5, and when no error flag is set, fetch and write requests pass straight to the memory side in the same cycle.
- R7: The queue holds DEPTH lines. While it is full, the response ready is low and a response is not accepted.
- R8: A failing result for the oldest tag removes that line without releasing it. It sets the sticky tamper flag from the next cycle, and from then until reset no fetch or write passes.
- R9: A result while the queue is empty, or with a tag other than the oldest, removes nothing. It sets the sticky protocol-error flag from the next cycle, which blocks fetches and writes until reset.
- R10: After reset the queue is empty, both flags are clear, the response ready is high and the release port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Gating policy (0 issue, 1 write, 2 fetch, 3 fetch and write) |
| rspValid | input | 1 | Memory read response valid |
| rspReady | output | 1 | Queue can accept a response |
| rspLineId | input | ID_W | Line identifier |
| rspCipher | input | DATA_W | Encrypted line |
| rspPad | input | DATA_W | Precomputed decryption pad |
| rspMac | input | MAC_W | MAC stored with the line |
| vreqValid | output | 1 | Verification request valid |
| vreqTag | output | TAG_W | Tag given to the line |
| vreqLineId | output | ID_W | Line identifier of the request |
| vreqCipher | output | DATA_W | Ciphertext to authenticate |
| vreqMac | output | MAC_W | Stored MAC to compare |
| resValid | input | 1 | Verification result valid |
| resTag | input | TAG_W | Tag of the result |
| resOk | input | 1 | 1 = MAC matched |
| relValid | output | 1 | Plaintext release valid |
| relLineId | output | ID_W | Line ID of released data |
| relData | output | DATA_W | Released plaintext |
| fetchReqValid | input | 1 | Core fetch request |
| fetchReqAddr | input | ADDR_W | Fetch address |
| fetchReqReady | output | 1 | Fetch may proceed |
| memFetchValid | output | 1 | Fetch launched to memory |
| memFetchAddr | output | ADDR_W | Fetch address to memory |
| wrReqValid | input | 1 | Core write request |
| wrReqAddr | input | ADDR_W | Write address |
| wrReqData | input | DATA_W | Write data |
| wrReqReady | output | 1 | Write may proceed |
| memWrValid | output | 1 | Write issued to memory |
| memWrAddr | output | ADDR_W | Write address to memory |
| memWrData | output | DATA_W | Write data to memory |
| tamper | output | 1 | Sticky MAC-failure flag |
| protoErr | output | 1 | Sticky result-order error flag |

## Verification
The hardest case to reach is a full queue under the combined fetch-and-write gate. In that case acceptance stops, both bus ports are gated, and results and new responses overlap in a single cycle. The stimulus holds the response valid for more cycles than the queue is deep, and only then starts retiring results while new lines are still offered. This pushes and pops in the same cycle at the full boundary.

The sticky error paths are also reached on purpose:
- A result carrying the next-oldest tag triggers the protocol error.
- A failing result on the head line, followed by a passing one, shows that only the failed line is discarded.

// File: rtl/authGatePkg.sv
package authGatePkg;

  typedef enum logic [1:0] {
    GATE_ISSUE = 2'd0,
    GATE_WRITE = 2'd1,
    GATE_FETCH = 2'd2,
    GATE_BOTH  = 2'd3
  } gateMode_t;

  typedef struct packed {
    logic push;     // accept a line into the queue
    logic pop;      // retire the oldest line
    logic relHead;  // release oldest line's plaintext
    logic relIn;    // release incoming line's plaintext
  } gateStrobes_t;

endpackage

// File: rtl/authGateDatapath.sv
module authGateDatapath
  import authGatePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strb,
  input  logic [DATA_W-1:0] cipherIn,
  input  logic [DATA_W-1:0] padIn,
  input  logic [ID_W-1:0]   lineIdIn,
  output logic              empty,
  output logic              full,
  output logic [TAG_W-1:0]  headTag,
  output logic [TAG_W-1:0]  nextTag,
  output logic              relValid,
  output logic [ID_W-1:0]   relLineId,
  output logic [DATA_W-1:0] relData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] plainMem [DEPTH];
  logic [ID_W-1:0]   idMem    [DEPTH];
  logic [TAG_W-1:0]  tagMem   [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] plainIn;

  assign plainIn = cipherIn ^ padIn;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign headTag = tagMem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) begin
      plainMem[wrPtr] <= plainIn;
      idMem[wrPtr]    <= lineIdIn;
      tagMem[wrPtr]   <= nextTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      nextTag <= '0;
    end else begin
      if (strb.push) begin
        wrPtr   <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
        nextTag <= nextTag + 1'b1;
      end
      if (strb.pop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relValid  <= 1'b0;
      relLineId <= '0;
      relData   <= '0;
    end else begin
      relValid <= strb.relHead | strb.relIn;
      if (strb.relHead) begin
        relData   <= plainMem[rdPtr];
        relLineId <= idMem[rdPtr];
      end else if (strb.relIn) begin
        relData   <= plainIn;
        relLineId <= lineIdIn;
      end
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (!full || strb.pop));

  p_fill_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> !empty);

endmodule

// File: rtl/authGateControl.sv
module authGateControl
  import authGatePkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             rspValid,
  input  logic             resValid,
  input  logic [TAG_W-1:0] resTag,
  input  logic             resOk,
  input  logic             empty,
  input  logic             full,
  input  logic [TAG_W-1:0] headTag,
  output gateStrobes_t     strb,
  output logic             rspReady,
  output logic             fetchReqReady,
  output logic             wrReqReady,
  output logic             tamper,
  output logic             protoErr
);

  gateMode_t policy;
  logic      accept;
  logic      resHit;
  logic      halted;

  assign policy   = gateMode_t'(mode);
  assign halted   = tamper | protoErr;
  assign rspReady = !full;
  assign accept   = rspValid & !full;
  assign resHit   = resValid & !empty & (resTag == headTag);

  assign fetchReqReady = !halted &&
    !(((policy == GATE_FETCH) || (policy == GATE_BOTH)) && !empty);
  assign wrReqReady = !halted &&
    !(((policy == GATE_WRITE) || (policy == GATE_BOTH)) && !empty);

  always_comb begin
    strb.push    = accept;
    strb.pop     = resHit;
    strb.relHead = resHit & resOk & (policy == GATE_ISSUE);
    strb.relIn   = accept & (policy != GATE_ISSUE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tamper   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (resHit && !resOk) tamper <= 1'b1;
      if (resValid && !resHit) protoErr <= 1'b1;
    end
  end

  p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.push) && mode[1]) |-> !fetchReqReady);

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.push) && mode[0]) |-> !wrReqReady);

  p_tamper_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    tamper |=> tamper);

  p_fail_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.pop && !resOk)) |-> (!fetchReqReady && !wrReqReady));

endmodule

// File: rtl/authGateQueue.sv
module authGateQueue
  import authGatePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int MAC_W  = 16,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [ID_W-1:0]   rspLineId,
  input  logic [DATA_W-1:0] rspCipher,
  input  logic [DATA_W-1:0] rspPad,
  input  logic [MAC_W-1:0]  rspMac,
  output logic              vreqValid,
  output logic [TAG_W-1:0]  vreqTag,
  output logic [ID_W-1:0]   vreqLineId,
  output logic [DATA_W-1:0] vreqCipher,
  output logic [MAC_W-1:0]  vreqMac,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic              resOk,
  output logic              relValid,
  output logic [ID_W-1:0]   relLineId,
  output logic [DATA_W-1:0] relData,
  input  logic              fetchReqValid,
  input  logic [ADDR_W-1:0] fetchReqAddr,
  output logic              fetchReqReady,
  output logic              memFetchValid,
  output logic [ADDR_W-1:0] memFetchAddr,
  input  logic              wrReqValid,
  input  logic [ADDR_W-1:0] wrReqAddr,
  input  logic [DATA_W-1:0] wrReqData,
  output logic              wrReqReady,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              tamper,
  output logic              protoErr
);

  gateStrobes_t     strb;
  logic             empty;
  logic             full;
  logic [TAG_W-1:0] headTag;
  logic [TAG_W-1:0] nextTag;

  authGateControl #(.TAG_W(TAG_W)) i_control (
    .clk           (clk),
    .rstN          (rstN),
    .mode          (mode),
    .rspValid      (rspValid),
    .resValid      (resValid),
    .resTag        (resTag),
    .resOk         (resOk),
    .empty         (empty),
    .full          (full),
    .headTag       (headTag),
    .strb          (strb),
    .rspReady      (rspReady),
    .fetchReqReady (fetchReqReady),
    .wrReqReady    (wrReqReady),
    .tamper        (tamper),
    .protoErr      (protoErr)
  );

  authGateDatapath #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .TAG_W  (TAG_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cipherIn  (rspCipher),
    .padIn     (rspPad),
    .lineIdIn  (rspLineId),
    .empty     (empty),
    .full      (full),
    .headTag   (headTag),
    .nextTag   (nextTag),
    .relValid  (relValid),
    .relLineId (relLineId),
    .relData   (relData)
  );

  assign vreqValid  = strb.push;
  assign vreqTag    = nextTag;
  assign vreqLineId = rspLineId;
  assign vreqCipher = rspCipher;
  assign vreqMac    = rspMac;

  assign memFetchValid = fetchReqValid & fetchReqReady;
  assign memFetchAddr  = fetchReqAddr;
  assign memWrValid    = wrReqValid & wrReqReady;
  assign memWrAddr     = wrReqAddr;
  assign memWrData     = wrReqData;

endmodule

// File: tb/test_authGateQueue.sv
`timescale 1ns/1ps
module test_authGateQueue;

  localparam int DEPTH = 8;

  typedef struct packed {
    logic [3:0]  tag;
    logic [7:0]  id;
    logic [31:0] plain;
  } entry_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        rspValid = 1'b0;
  logic        rspReady;
  logic [7:0]  rspLineId = '0;
  logic [31:0] rspCipher = '0;
  logic [31:0] rspPad = '0;
  logic [15:0] rspMac = '0;
  logic        vreqValid;
  logic [3:0]  vreqTag;
  logic [7:0]  vreqLineId;
  logic [31:0] vreqCipher;
  logic [15:0] vreqMac;
  logic        resValid = 1'b0;
  logic [3:0]  resTag = '0;
  logic        resOk = 1'b0;
  logic        relValid;
  logic [7:0]  relLineId;
  logic [31:0] relData;
  logic        fetchReqValid = 1'b0;
  logic [31:0] fetchReqAddr = '0;
  logic        fetchReqReady;
  logic        memFetchValid;
  logic [31:0] memFetchAddr;
  logic        wrReqValid = 1'b0;
  logic [31:0] wrReqAddr = '0;
  logic [31:0] wrReqData = '0;
  logic        wrReqReady;
  logic        memWrValid;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic        tamper;
  logic        protoErr;

  always #2 clk = ~clk;

  authGateQueue i_authGateQueue (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  entry_t      q[$];
  logic [3:0]  mNextTag;
  logic        mTamper, mProto, mRelValid;
  logic [7:0]  mRelId;
  logic [31:0] mRelData;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    q.delete();
    mNextTag = '0; mTamper = 0; mProto = 0; mRelValid = 0; mRelId = '0; mRelData = '0;
  endtask

  // Compare all outputs with the model, then advance the model across one edge.
  task automatic step();
    bit acc, halt, relNow, hit;
    int n;
    entry_t head;
    #1;
    n    = q.size();
    halt = mTamper | mProto;
    acc  = rspValid && (n < DEPTH);
    chk(rspReady, n < DEPTH, "R7 rspReady");
    chk(vreqValid, acc, "R3 vreqValid");
    if (acc) begin
      chk(vreqTag, mNextTag, "R3 vreqTag");
      chk(vreqLineId, rspLineId, "R3 vreqLineId");
      chk(vreqCipher, rspCipher, "R3 vreqCipher");
      chk(vreqMac, rspMac, "R3 vreqMac");
    end
    chk(fetchReqReady, !halt && !(mode[1] && n != 0), "R5 fetchReqReady");
    chk(memFetchValid, fetchReqValid && !halt && !(mode[1] && n != 0), "R6 memFetchValid");
    if (memFetchValid) chk(memFetchAddr, fetchReqAddr, "R6 memFetchAddr");
    chk(wrReqReady, !halt && !(mode[0] && n != 0), "R4 wrReqReady");
    chk(memWrValid, wrReqValid && !halt && !(mode[0] && n != 0), "R6 memWrValid");
    if (memWrValid) chk(memWrData, wrReqData, "R6 memWrData");
    chk(tamper, mTamper, "R8 tamper");
    chk(protoErr, mProto, "R9 protoErr");
    chk(relValid, mRelValid, (mode == 2'd0) ? "R2 relValid" : "R1 relValid");
    if (mRelValid) begin
      chk(relData, mRelData, "R1 relData");
      chk(relLineId, mRelId, "R1 relLineId");
    end
    relNow = 0;
    hit = 0;
    if (resValid) begin
      if (n == 0) mProto = 1;
      else if (q[0].tag != resTag) mProto = 1;
      else begin
        hit  = 1;
        head = q.pop_front();
        if (!resOk) mTamper = 1;
        else if (mode == 2'd0) begin
          relNow = 1; mRelData = head.plain; mRelId = head.id;
        end
      end
    end
    if (acc) begin
      q.push_back({mNextTag, rspLineId, rspCipher ^ rspPad});
      mNextTag = mNextTag + 1'b1;
      if (mode != 2'd0) begin
        relNow = 1; mRelData = rspCipher ^ rspPad; mRelId = rspLineId;
      end
    end
    mRelValid = relNow;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; rspValid = 0; resValid = 0; fetchReqValid = 0; wrReqValid = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    #1;
    chk(rspReady, 1, "R10 rspReady after reset");
    chk(relValid, 0, "R10 relValid after reset");
    chk(tamper, 0, "R10 tamper after reset");
    chk(protoErr, 0, "R10 protoErr after reset");
    chk(fetchReqReady, 1, "R10 fetch ready after reset");
  endtask

  task automatic setLine(input int i);
    rspValid  = 1;
    rspLineId = 8'(8'h10 + i);
    rspCipher = 32'hC0DE0000 ^ (32'(i) * 32'h01010101);
    rspPad    = 32'h5A5A00FF + 32'(i * 7);
    rspMac    = 16'(16'hBEE0 + i);
  endtask

  task automatic sendLine(input int i);
    setLine(i);
    step();
    rspValid = 0;
  endtask

  task automatic sendResult(input logic ok);
    resValid = 1;
    resOk    = ok;
    resTag   = (q.size() != 0) ? q[0].tag : 4'd0;
    step();
    resValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // Policy 1: early release, writes gated while pending (R1, R4, R6)
    mode = 2'd1;
    step();
    wrReqValid = 1; wrReqAddr = 32'h1000; wrReqData = 32'h1234;
    fetchReqValid = 1; fetchReqAddr = 32'h2000;
    for (int i = 0; i < 3; i++) sendLine(i);
    step();
    chk(wrReqReady, 0, "R4 write held with lines pending");
    for (int i = 0; i < 3; i++) sendResult(1);
    step();
    chk(memWrValid, 1, "R4 write passes once drained");
    wrReqValid = 0; fetchReqValid = 0;

    // Policy 0: hold until verified, release in order (R2, R6)
    mode = 2'd0;
    step();
    fetchReqValid = 1; wrReqValid = 1;
    for (int i = 3; i < 6; i++) sendLine(i);
    repeat (3) step();
    chk(relValid, 0, "R2 no release before verification");
    resValid = 1; resOk = 1; resTag = q[0].tag; setLine(6);
    step();
    rspValid = 0; resValid = 0;
    while (q.size() != 0) sendResult(1);
    step();
    fetchReqValid = 0; wrReqValid = 0;

    // Policy 2: fetches gated, writes free (R5, R6)
    mode = 2'd2;
    step();
    fetchReqValid = 1; wrReqValid = 1;
    sendLine(7);
    sendLine(8);
    chk(memFetchValid, 0, "R5 fetch held with lines pending");
    chk(memWrValid, 1, "R6 write free in fetch policy");
    sendResult(1);
    sendResult(1);
    step();
    chk(memFetchValid, 1, "R5 fetch passes once drained");

    // Policy 3: fill past depth, overlapping results (R7, R3 tag wrap)
    mode = 2'd3;
    step();
    for (int i = 0; i < 11; i++) begin
      setLine(20 + i);
      step();
    end
    chk(rspReady, 0, "R7 ready low when full");
    for (int i = 0; i < 6; i++) begin
      setLine(40 + i);
      resValid = 1; resOk = 1; resTag = q[0].tag;
      step();
    end
    rspValid = 0; resValid = 0;
    while (q.size() != 0) sendResult(1);
    step();
    fetchReqValid = 0; wrReqValid = 0;

    // Protocol error: wrong tag, then result while empty (R9)
    mode = 2'd0;
    step();
    sendLine(50);
    sendLine(51);
    resValid = 1; resOk = 1; resTag = q[0].tag + 4'd1;
    step();
    resValid = 0;
    fetchReqValid = 1; wrReqValid = 1;
    step();
    chk(protoErr, 1, "R9 protoErr latched");
    chk(memFetchValid, 0, "R9 fetch blocked after protocol error");
    fetchReqValid = 0; wrReqValid = 0;
    doReset();
    mode = 2'd0;
    resValid = 1; resOk = 1; resTag = 4'd0;
    step();
    resValid = 0;
    step();
    chk(protoErr, 1, "R9 result on empty queue");
    doReset();

    // Tamper: head fails, next passes (R8)
    mode = 2'd0;
    step();
    sendLine(60);
    sendLine(61);
    sendResult(0);
    chk(relValid, 0, "R8 failed line discarded");
    chk(tamper, 1, "R8 tamper latched");
    sendResult(1);
    fetchReqValid = 1; wrReqValid = 1;
    repeat (3) step();
    chk(memFetchValid, 0, "R8 fetch blocked after tamper");
    chk(memWrValid, 0, "R8 write blocked after tamper");
    doReset();
    fetchReqValid = 1;
    step();
    chk(memFetchValid, 1, "R10 fetch restored after reset");
    fetchReqValid = 0;
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule